// File: doc/BRIEF.md
# Way-Lockable Cache Replacement Controller

This block manages replacement and line locking for a 4-way set-associative cache. It keeps, for every way of every set, a 3-bit line state and a 2-bit recency age. A small lock tag is kept with each way. The line state is one of four coherence states or one of two locked states. A locked way is never chosen for eviction. It stays resident until a write command gives it an unlocked state, and that unlock always leaves the way invalid, so no write-back is ever owed for it.

Around the block, the lookup logic reports hits so that recency can be updated. The miss path offers a set for allocation and reads back the chosen victim way, or a flag saying that every way of the set is locked. A test-register style command port reads or writes the state of one chosen way, or cleans every modified line. A cache-wide invalidate input and two resets act on the whole store. The warm reset keeps all lock information. Only the power-on reset clears it.

Top module: `wlk_repl_ctrl`

## Requirements
- R1: Command codes on `cmd_op` are 0 clean, 1 write, 2 read and 3 no operation. State codes are 0 invalid, 1 shared, 2 exclusive, 3 modified, 4 locked-valid and 5 locked-invalid. An accepted write stores `cmd_state` and `cmd_tag` in the addressed way. A read raises `rd_vld` for one cycle at the next clock edge and returns that way's state, tag and age.
- R2: A write with state code 6 or 7 changes nothing and raises `cmd_err` for one cycle at the next edge.
- R3: A write of code 4 whose tag equals the tag of another way of the same set that is already in code 4 changes nothing and raises `cmd_err`.
- R4: A write of a code 0 to 3 to a way in code 4 or 5 stores code 0, whatever code was requested, together with the new tag.
- R5: `victim_way` for `alloc_set` never names a way in code 4 or 5. If an unlocked way is in code 0, the lowest-numbered such way is chosen. Otherwise the unlocked way with the greatest age is chosen.
- R6: When all four ways of `alloc_set` are in code 4 or 5, `no_victim` is 1, and an allocation request changes no state and no age.
- R7: A hit, or an accepted allocation, sets the touched way's age to 0 and adds 1 to every way of that set whose age was below the touched way's old age. The four ages of a set are always a permutation of 0 to 3.
- R8: An accepted allocation puts the victim way into code 2.
- R9: A clean command turns every way in code 3 into code 2 in all sets and leaves every other state and every age unchanged.
- R10: `inv_all` puts every way not in code 4 or 5 into code 0. Locked states, tags and ages are unchanged.
- R11: A warm reset (`rst_n` low, `por_n` high) puts every unlocked way into code 0, keeps locked states and all tags, and resets the age of way w to w.
- R12: A power-on reset (`por_n` low) puts every way into code 0 with tag 0 and sets the age of way w to w.
- R13: In one cycle only one action takes effect, in this order of priority: `inv_all`, then `cmd_vld` (any code), then `alloc_vld`, then `hit_vld`. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| inv_all | input | 1 | Invalidate every unlocked way |
| hit_vld | input | 1 | Lookup hit report |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | 2 | Way of the hit |
| alloc_vld | input | 1 | Allocation request |
| alloc_set | input | SET_W | Set to allocate in |
| victim_way | output | 2 | Chosen victim for alloc_set |
| no_victim | output | 1 | Every way of alloc_set is locked |
| cmd_vld | input | 1 | Command valid |
| cmd_op | input | 2 | Command code |
| cmd_set | input | SET_W | Command set |
| cmd_way | input | 2 | Command way |
| cmd_state | input | 3 | State code to write |
| cmd_tag | input | TAG_W | Lock tag to write |
| rd_vld | output | 1 | Read data valid |
| rd_state | output | 3 | Read state code |
| rd_tag | output | TAG_W | Read tag |
| rd_age | output | 2 | Read recency age |
| cmd_err | output | 1 | Rejected write |

## Verification
The hardest situation to reach is a duplicate lock inside one set. It needs one way already locked with a tag, and then a locked write to a different way of the same set carrying the same tag. The same stimulus has to reach the state where all four ways of a set are locked, so that `no_victim` and the dropped allocation can be seen. The random phase therefore sends most traffic to two sets, draws tags from only four values, and weights writes towards the locked-valid code. Occasional unlocking writes reopen the sets, so victim choice keeps moving between the invalid-first rule and the oldest-age rule. Directed steps come first and cover the lock conflict, the fully locked set, the unlock rule, the survival of locks through a warm reset, and the priority between simultaneous actions.

// File: rtl/wlk_pkg.sv
// Shared types and codes for the way-lock replacement controller.
// Assumes a fixed 4-way organisation; the age width follows the way count.
package wlk_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;

    // Per-way line state; codes 4 and 5 carry the lock.
    typedef enum logic [2:0] {
        WS_INV = 3'd0,
        WS_SHR = 3'd1,
        WS_EXC = 3'd2,
        WS_MOD = 3'd3,
        WS_LKV = 3'd4,
        WS_LKI = 3'd5
    } wst_t;

    localparam logic [1:0] OP_CLEAN = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_READ  = 2'd2;
    localparam logic [1:0] OP_NOP   = 2'd3;

    function automatic logic is_locked(wst_t s);
        return (s == WS_LKV) || (s == WS_LKI);
    endfunction
endpackage

// File: rtl/wlk_recency.sv
// Next-age computation for one set when one way is touched.
// Assumes the incoming ages are a permutation; the output stays one.
module wlk_recency
    import wlk_pkg::*;
(
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    input  logic [WAY_W-1:0]           way_i,
    output logic [WAYS-1:0][AGE_W-1:0] age_o
);
    // Touched way becomes youngest; younger ways than it grow older by one.
    always_comb begin
        for (int v = 0; v < WAYS; v++) begin
            if (v == int'(way_i))
                age_o[v] = '0;
            else if (age_i[v] < age_i[way_i])
                age_o[v] = age_i[v] + 1'b1;
            else
                age_o[v] = age_i[v];
        end
    end
endmodule

// File: rtl/wlk_victim.sv
// Victim choice for one set: lowest invalid way first, else the oldest
// unlocked way. Reports none_o when every way is locked.
// Assumes ages within the set are distinct.
module wlk_victim
    import wlk_pkg::*;
(
    input  wst_t [WAYS-1:0]            st_i,
    input  logic [WAYS-1:0][AGE_W-1:0] age_i,
    output logic [WAY_W-1:0]           way_o,
    output logic                       none_o
);
    logic             found_inv;
    logic [WAY_W-1:0] inv_way;
    logic             have_old;
    logic [WAY_W-1:0] old_way;
    logic [AGE_W-1:0] old_age;

    // Scan for the lowest-numbered invalid way.
    always_comb begin
        found_inv = 1'b0;
        inv_way   = '0;
        for (int v = WAYS - 1; v >= 0; v--) begin
            if (st_i[v] == WS_INV) begin
                found_inv = 1'b1;
                inv_way   = WAY_W'(v);
            end
        end
    end

    // Scan for the oldest unlocked way.
    always_comb begin
        have_old = 1'b0;
        old_way  = '0;
        old_age  = '0;
        for (int v = 0; v < WAYS; v++) begin
            if (!is_locked(st_i[v]) && (!have_old || age_i[v] > old_age)) begin
                have_old = 1'b1;
                old_way  = WAY_W'(v);
                old_age  = age_i[v];
            end
        end
    end

    // Combine both scans into the final choice.
    always_comb begin
        way_o  = found_inv ? inv_way : old_way;
        none_o = !have_old;
    end
endmodule

// File: rtl/wlk_lock_check.sv
// Screens a write command: flags undefined state codes and a locked-valid
// write whose tag already sits locked-valid in another way of the set.
module wlk_lock_check
    import wlk_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  wst_t [WAYS-1:0]            st_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
    input  logic [WAY_W-1:0]           way_i,
    input  logic [2:0]                 code_i,
    input  logic [TAG_W-1:0]           tag_in,
    output logic                       bad_code_o,
    output logic                       dup_lock_o
);
    // Undefined codes lie above the last locked encoding.
    always_comb bad_code_o = (code_i > 3'd5);

    // Compare the requested lock tag against other locked-valid ways.
    always_comb begin
        dup_lock_o = 1'b0;
        if (code_i == 3'd4) begin
            for (int v = 0; v < WAYS; v++) begin
                if (v != int'(way_i) && st_i[v] == WS_LKV && tag_i[v] == tag_in)
                    dup_lock_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wlk_repl_ctrl.sv
// Top of the way-lock replacement controller. Holds state, lock tag and
// age for every way of every set, applies one action per cycle
// (invalidate-all > command > allocate > hit), and offers the victim for
// alloc_set combinationally. Resets are synchronous and active low;
// por_n clears locks, rst_n keeps them.
module wlk_repl_ctrl
    import wlk_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 8,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic             hit_vld,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             alloc_vld,
    input  logic [SET_W-1:0] alloc_set,
    output logic [WAY_W-1:0] victim_way,
    output logic             no_victim,
    input  logic             cmd_vld,
    input  logic [1:0]       cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    input  logic [2:0]       cmd_state,
    input  logic [TAG_W-1:0] cmd_tag,
    output logic             rd_vld,
    output logic [2:0]       rd_state,
    output logic [TAG_W-1:0] rd_tag,
    output logic [AGE_W-1:0] rd_age,
    output logic             cmd_err
);
    wst_t [WAYS-1:0]            st_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
    logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];

    logic                       alloc_go;
    logic [SET_W-1:0]           touch_set;
    logic [WAY_W-1:0]           touch_way;
    logic [WAYS-1:0][AGE_W-1:0] age_nx;
    logic                       bad_code;
    logic                       dup_lock;
    wst_t                       cur_st;

    wlk_victim u_victim (
        .st_i   (st_q[alloc_set]),
        .age_i  (age_q[alloc_set]),
        .way_o  (victim_way),
        .none_o (no_victim)
    );

    wlk_lock_check #(.TAG_W(TAG_W)) u_lock_check (
        .st_i       (st_q[cmd_set]),
        .tag_i      (tag_q[cmd_set]),
        .way_i      (cmd_way),
        .code_i     (cmd_state),
        .tag_in     (cmd_tag),
        .bad_code_o (bad_code),
        .dup_lock_o (dup_lock)
    );

    wlk_recency u_recency (
        .age_i (age_q[touch_set]),
        .way_i (touch_way),
        .age_o (age_nx)
    );

    // Decide whether an allocation wins this cycle and what gets touched.
    always_comb begin
        alloc_go  = alloc_vld && !no_victim && !cmd_vld && !inv_all;
        touch_set = alloc_go ? alloc_set : hit_set;
        touch_way = alloc_go ? victim_way : hit_way;
        cur_st    = st_q[cmd_set][cmd_way];
    end

    // State, tag, age and response registers with the priority chain.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    st_q[s][w]  <= WS_INV;
                    tag_q[s][w] <= '0;
                    age_q[s][w] <= AGE_W'(w);
                end
            rd_vld   <= 1'b0;
            rd_state <= '0;
            rd_tag   <= '0;
            rd_age   <= '0;
            cmd_err  <= 1'b0;
        end else if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    if (!is_locked(st_q[s][w]))
                        st_q[s][w] <= WS_INV;
                    age_q[s][w] <= AGE_W'(w);
                end
            rd_vld  <= 1'b0;
            cmd_err <= 1'b0;
        end else begin
            rd_vld  <= 1'b0;
            cmd_err <= 1'b0;
            if (inv_all) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (!is_locked(st_q[s][w]))
                            st_q[s][w] <= WS_INV;
            end else if (cmd_vld) begin
                case (cmd_op)
                    OP_CLEAN: begin
                        for (int s = 0; s < SETS; s++)
                            for (int w = 0; w < WAYS; w++)
                                if (st_q[s][w] == WS_MOD)
                                    st_q[s][w] <= WS_EXC;
                    end
                    OP_WRITE: begin
                        if (bad_code || dup_lock) begin
                            cmd_err <= 1'b1;
                        end else begin
                            st_q[cmd_set][cmd_way] <= (is_locked(cur_st) && !cmd_state[2])
                                                      ? WS_INV : wst_t'(cmd_state);
                            tag_q[cmd_set][cmd_way] <= cmd_tag;
                        end
                    end
                    OP_READ: begin
                        rd_vld   <= 1'b1;
                        rd_state <= cur_st;
                        rd_tag   <= tag_q[cmd_set][cmd_way];
                        rd_age   <= age_q[cmd_set][cmd_way];
                    end
                    default: ;
                endcase
            end else if (alloc_go) begin
                age_q[alloc_set]             <= age_nx;
                st_q[alloc_set][victim_way]  <= WS_EXC;
            end else if (hit_vld) begin
                age_q[hit_set] <= age_nx;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [WAYS-1:0] lk_vec;
    // Gather the lock flags of the allocation set for the checks below.
    always_comb
        for (int w = 0; w < WAYS; w++)
            lk_vec[w] = is_locked(st_q[alloc_set][w]);

    // R5
    victim_unlocked_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !no_victim |-> !lk_vec[victim_way]);

    // R6
    no_victim_locked_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        no_victim |-> (lk_vec == '1));

    // R1
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        rd_vld |-> $past(cmd_vld && !inv_all && cmd_op == OP_READ));

    // R2
    err_source_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        cmd_err |-> $past(cmd_vld && !inv_all && cmd_op == OP_WRITE));

    // R11
    warm_lock_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (is_locked(st_q[0][0]) == $past(is_locked(st_q[0][0]))));

    for (genvar gs = 0; gs < SETS; gs++) begin : g_perm
        logic [WAYS-1:0] seen;
        // Mark which age values occur in this set.
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++)
                seen[age_q[gs][w]] = 1'b1;
        end
        // R7
        age_perm_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
            seen == '1);
    end
endmodule

// File: tb/tb_wlk_repl_ctrl.sv
`timescale 1ns/1ps
module tb_wlk_repl_ctrl;
    import wlk_pkg::*;
    localparam int SETS  = 8;
    localparam int TAG_W = 8;
    localparam int SET_W = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             por_n, rst_n, inv_all;
    logic             hit_vld, alloc_vld, cmd_vld;
    logic [SET_W-1:0] hit_set, alloc_set, cmd_set;
    logic [1:0]       hit_way, cmd_way, cmd_op;
    logic [2:0]       cmd_state;
    logic [TAG_W-1:0] cmd_tag;
    logic [1:0]       victim_way;
    logic             no_victim, rd_vld, cmd_err;
    logic [2:0]       rd_state;
    logic [TAG_W-1:0] rd_tag;
    logic [1:0]       rd_age;

    wlk_repl_ctrl #(.SETS(SETS), .TAG_W(TAG_W)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .inv_all(inv_all),
        .hit_vld(hit_vld), .hit_set(hit_set), .hit_way(hit_way),
        .alloc_vld(alloc_vld), .alloc_set(alloc_set),
        .victim_way(victim_way), .no_victim(no_victim),
        .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_set(cmd_set), .cmd_way(cmd_way),
        .cmd_state(cmd_state), .cmd_tag(cmd_tag),
        .rd_vld(rd_vld), .rd_state(rd_state), .rd_tag(rd_tag), .rd_age(rd_age),
        .cmd_err(cmd_err)
    );

    int m_st  [SETS][4];
    int m_tag [SETS][4];
    int m_age [SETS][4];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic bit lk(int s);
        return (s == 4) || (s == 5);
    endfunction

    function automatic int exp_victim(int s, output bit none);
        int best;
        none = 0;
        for (int w = 0; w < 4; w++)
            if (m_st[s][w] == 0) return w;
        best = -1;
        for (int w = 0; w < 4; w++)
            if (!lk(m_st[s][w]) && (best < 0 || m_age[s][w] > m_age[s][best]))
                best = w;
        none = (best < 0);
        return (best < 0) ? 0 : best;
    endfunction

    function automatic bit dup_lock(int s, int w, int t);
        for (int v = 0; v < 4; v++)
            if (v != w && m_st[s][v] == 4 && m_tag[s][v] == t) return 1;
        return 0;
    endfunction

    task automatic touch(int s, int w);
        int a = m_age[s][w];
        for (int v = 0; v < 4; v++) begin
            if (v == w) m_age[s][v] = 0;
            else if (m_age[s][v] < a) m_age[s][v] = m_age[s][v] + 1;
        end
    endtask

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        inv_all = 0; hit_vld = 0; alloc_vld = 0; cmd_vld = 0;
    endtask

    // One clock: check victim, update model, check registered responses.
    task automatic tick(string req);
        bit none;
        int vw;
        int er = 0, ex = 0, es = 0, et = 0, ea = 0;
        int s, w;
        #1;
        vw = exp_victim(int'(alloc_set), none);
        if (alloc_vld) begin
            chk(none ? "R6" : "R5", int'(no_victim), int'(none), "no_victim");
            if (!none) chk("R5", int'(victim_way), vw, "victim_way");
        end
        if (!por_n) begin
            for (int a = 0; a < SETS; a++)
                for (int b = 0; b < 4; b++) begin
                    m_st[a][b] = 0; m_tag[a][b] = 0; m_age[a][b] = b;
                end
        end else if (!rst_n) begin
            for (int a = 0; a < SETS; a++)
                for (int b = 0; b < 4; b++) begin
                    if (!lk(m_st[a][b])) m_st[a][b] = 0;
                    m_age[a][b] = b;
                end
        end else if (inv_all) begin
            for (int a = 0; a < SETS; a++)
                for (int b = 0; b < 4; b++)
                    if (!lk(m_st[a][b])) m_st[a][b] = 0;
        end else if (cmd_vld) begin
            s = int'(cmd_set); w = int'(cmd_way);
            case (cmd_op)
                2'd0: for (int a = 0; a < SETS; a++)
                          for (int b = 0; b < 4; b++)
                              if (m_st[a][b] == 3) m_st[a][b] = 2;
                2'd1: begin
                    if (cmd_state > 5) ex = 1;
                    else if (cmd_state == 4 && dup_lock(s, w, int'(cmd_tag))) ex = 1;
                    else begin
                        m_st[s][w]  = (lk(m_st[s][w]) && cmd_state < 4) ? 0 : int'(cmd_state);
                        m_tag[s][w] = int'(cmd_tag);
                    end
                end
                2'd2: begin
                    er = 1; es = m_st[s][w]; et = m_tag[s][w]; ea = m_age[s][w];
                end
                default: ;
            endcase
        end else if (alloc_vld && !none) begin
            touch(int'(alloc_set), vw);
            m_st[int'(alloc_set)][vw] = 2;
        end else if (hit_vld) begin
            touch(int'(hit_set), int'(hit_way));
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, int'(rd_vld), er, "rd_vld");
        if (er != 0) begin
            chk(req, int'(rd_state), es, "rd_state");
            chk(req, int'(rd_tag), et, "rd_tag");
            chk(req, int'(rd_age), ea, "rd_age");
        end
        chk(req, int'(cmd_err), ex, "cmd_err");
    endtask

    task automatic do_write(int s, int w, int st, int t, string req);
        cmd_vld = 1; cmd_op = 2'd1; cmd_set = SET_W'(s); cmd_way = 2'(w);
        cmd_state = 3'(st); cmd_tag = TAG_W'(t);
        tick(req); idle();
    endtask

    task automatic do_read(int s, int w, string req);
        cmd_vld = 1; cmd_op = 2'd2; cmd_set = SET_W'(s); cmd_way = 2'(w);
        tick(req); idle();
    endtask

    task automatic do_alloc(int s, string req);
        alloc_vld = 1; alloc_set = SET_W'(s);
        tick(req); idle();
    endtask

    task automatic do_hit(int s, int w, string req);
        hit_vld = 1; hit_set = SET_W'(s); hit_way = 2'(w);
        tick(req); idle();
    endtask

    task automatic do_clean(string req);
        cmd_vld = 1; cmd_op = 2'd0;
        tick(req); idle();
    endtask

    task automatic do_inv(string req);
        inv_all = 1;
        tick(req); idle();
    endtask

    task automatic do_warm(string req);
        rst_n = 0; tick(req); tick(req); rst_n = 1;
    endtask

    task automatic do_por(string req);
        por_n = 0; tick(req); tick(req); por_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        por_n = 0; rst_n = 1; idle();
        hit_set = '0; hit_way = '0; alloc_set = '0; cmd_set = '0; cmd_way = '0;
        cmd_op = 2'd3; cmd_state = '0; cmd_tag = '0;
        @(negedge clk);
        do_por("R12");
        do_read(0, 2, "R12");
        do_read(5, 3, "R12");
        // basic write/read and code screening
        do_write(1, 1, 3, 9, "R1");
        do_read(1, 1, "R1");
        do_write(1, 1, 7, 5, "R2");
        do_write(1, 2, 6, 5, "R2");
        do_read(1, 1, "R2");
        // allocation and recency
        do_alloc(1, "R8");
        do_read(1, 0, "R8");
        do_hit(1, 3, "R7");
        do_read(1, 3, "R7");
        do_read(1, 0, "R7");
        do_clean("R9");
        do_read(1, 1, "R9");
        // fully locked set
        for (int w = 0; w < 4; w++) do_write(3, w, 4, w + 1, "R3");
        do_alloc(3, "R6");
        do_read(3, 0, "R6");
        do_read(3, 3, "R6");
        // duplicate lock tag
        do_write(3, 1, 4, 1, "R3");
        do_read(3, 1, "R3");
        // unlock forces invalid
        do_write(3, 1, 3, 7, "R4");
        do_read(3, 1, "R4");
        do_alloc(3, "R5");
        do_read(3, 1, "R5");
        // invalidate-all keeps locks
        do_write(2, 0, 3, 1, "R10");
        do_write(2, 1, 5, 2, "R10");
        do_inv("R10");
        do_read(2, 0, "R10");
        do_read(2, 1, "R10");
        // warm reset keeps locks
        do_warm("R11");
        do_read(3, 0, "R11");
        do_read(3, 1, "R11");
        do_read(2, 1, "R11");
        do_read(3, 2, "R11");
        // priority between simultaneous actions
        cmd_vld = 1; cmd_op = 2'd1; cmd_set = 0; cmd_way = 0; cmd_state = 1; cmd_tag = 3;
        alloc_vld = 1; alloc_set = 0; hit_vld = 1; hit_set = 0; hit_way = 3;
        tick("R13"); idle();
        do_read(0, 0, "R13");
        do_read(0, 3, "R13");
        inv_all = 1; cmd_vld = 1; cmd_op = 2'd1; cmd_set = 4; cmd_way = 2;
        cmd_state = 3; cmd_tag = 8;
        tick("R13"); idle();
        do_read(4, 2, "R13");
        alloc_vld = 1; alloc_set = 5; hit_vld = 1; hit_set = 5; hit_way = 2;
        tick("R13"); idle();
        do_read(5, 2, "R13");
        // constrained random phase
        for (int i = 0; i < 5000; i++) begin
            int r;
            if ($urandom % 600 == 0) begin
                do_warm("R11");
            end else begin
                inv_all   = ($urandom % 100) < 2;
                cmd_vld   = ($urandom % 100) < 45;
                alloc_vld = ($urandom % 100) < 40;
                hit_vld   = ($urandom % 100) < 40;
                r = $urandom % 100;
                cmd_op = (r < 50) ? 2'd1 : (r < 85) ? 2'd2 : (r < 90) ? 2'd0 : 2'd3;
                cmd_set   = (($urandom % 4) != 0) ? SET_W'($urandom % 2) : SET_W'($urandom);
                alloc_set = (($urandom % 4) != 0) ? SET_W'($urandom % 2) : SET_W'($urandom);
                hit_set   = SET_W'($urandom % 2);
                cmd_way   = 2'($urandom);
                hit_way   = 2'($urandom);
                r = $urandom % 100;
                cmd_state = (r < 45) ? 3'd4 : (r < 55) ? 3'd5 : (r < 62) ? 3'(6 + $urandom % 2)
                                                                          : 3'($urandom % 4);
                cmd_tag   = TAG_W'($urandom % 4);
                tick("R1");
                idle();
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule